// File: doc/BRIEF.md
# Command Bus Bandwidth Checker

This block decides when a memory command may go out on a shared command bus without exceeding a fixed number of commands per command window. Time is split into windows of `2**WIN_LOG2` cycles that start at multiples of the window length. A small booking table holds how many commands are already placed in each upcoming window. A requester offers the cycle it would like, the kind of command, the per-window limit and, for two-part commands, the largest allowed separation in windows. The block replies with the cycle at which the command, or each of its two parts, may issue.

The search advances one window per clock cycle. A single-cycle command slides forward window by window until it finds a window with spare capacity. A two-part command looks for a pair of windows, the first no more than the allowed separation before the second, where both parts fit at the same time. Every grant is booked in the same clock edge that issues it, so the next request already sees it. Windows that lie wholly in the past are dropped from the table. If the table has no free entry for a window that needs one, the search waits until an entry is dropped.

Top module: `cmd_bus_budget`

## Requirements
- R1: A single-cycle command whose requested window holds fewer than the limit is granted at its requested cycle; for single-cycle commands `grantFirst` equals `grantSecond`.
- R2: Windows start at cycles whose low `WIN_LOG2` bits are zero; a command moved out of its requested window is granted at the first cycle of its new window.
- R3: When a window holds the limit, a single-cycle command moves to the next window, repeating until a window with room is found.
- R4: A two-part command first tries a first-part window `reqMaxGapWin` windows before the second part's window, never earlier than the current window; `grantFirst` is the later of that window's start and the current cycle, and `grantFirst` never exceeds `grantSecond`.
- R5: When both parts fall in one window, that window needs room for two commands (count plus one below the limit).
- R6: If the second part lacks room it moves one window later; the first part moves one window later if it lacks room, or if the second part moved and the separation would exceed `reqMaxGapWin` windows.
- R7: A grant is booked in the same edge that raises `grantValid`, so a request accepted next sees it.
- R8: A booking whose window ends at or before the current cycle is removed from the table.
- R9: When the table has too few free entries for the windows a grant needs, no grant is issued until pruning frees enough entries.
- R10: After reset `reqReady` is 1 and `grantValid` is 0; `reqReady` is 0 while a search runs, and `grantValid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nowCycle | input | TIME_W | Current cycle number, advancing by one each clock |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqCycle | input | TIME_W | Desired issue cycle (of the second part for two-part commands) |
| reqTwoPart | input | 1 | 1 for a two-part command, 0 for single-cycle |
| reqMaxCmds | input | CNT_W | Commands allowed per window |
| reqMaxGapWin | input | GAP_W | Largest separation of the two parts, in windows |
| grantValid | output | 1 | One-cycle pulse with the granted cycles |
| grantFirst | output | TIME_W | Granted cycle of the first part (equals grantSecond for single-cycle) |
| grantSecond | output | TIME_W | Granted cycle of the command or its second part |

## Verification
The assertions take for granted that `nowCycle` rises by exactly one per clock, that no request names a cycle earlier than `nowCycle`, that the limit is at least one, and that a two-part command under a limit of one is given a separation of at least one window so a pair can always be found. The bench drives `nowCycle` from its own cycle counter, places every request a few windows ahead of the current cycle, and lets enough time pass between scenarios for old bookings to age out. Its limits and separations stay in the ranges above, and the table-full case is built from requests far enough ahead that filling the table finishes before any of its windows expire.

// File: rtl/cmdbw_pkg.sv
package cmdbw_pkg;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } bw_state_e;

  // Strobes from the control to the booking table
  typedef struct packed {
    logic bookA;    // book the first part of a two-part command
    logic bookB;    // book the single command or the second part
    logic sameWin;  // both parts land in one window
  } book_strobe_t;

endpackage

// File: rtl/cmdbw_table.sv
module cmdbw_table
  import cmdbw_pkg::*;
#(
  parameter int TIME_W   = 32,
  parameter int WIN_LOG2 = 2,
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] nowCycle,
  input  logic [TIME_W-1:0] qryA,
  input  logic [TIME_W-1:0] qryB,
  input  book_strobe_t      strobe,
  output logic [CNT_W-1:0]  cntA,
  output logic [CNT_W-1:0]  cntB,
  output logic              hitA,
  output logic              hitB,
  output logic              freeAny,
  output logic              freeTwo
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [TIME_W-1:0] WIN_LEN    = TIME_W'(1) << WIN_LOG2;
  localparam logic [TIME_W-1:0] ALIGN_MASK = ~(WIN_LEN - TIME_W'(1));

  logic              entValid [DEPTH];
  logic [TIME_W-1:0] entWin   [DEPTH];
  logic [CNT_W-1:0]  entCnt   [DEPTH];

  logic              nxtValid [DEPTH];
  logic [TIME_W-1:0] nxtWin   [DEPTH];
  logic [CNT_W-1:0]  nxtCnt   [DEPTH];

  logic [TIME_W-1:0] nowWin;
  logic [IDX_W-1:0]  idxA, idxB, freeIdx0, freeIdx1, slotB;
  logic [1:0]        nFree;
  logic [CNT_W-1:0]  incA;

  assign nowWin = nowCycle & ALIGN_MASK;

  // Lookup of the two query windows
  always_comb begin
    hitA = 1'b0; idxA = '0; cntA = '0;
    hitB = 1'b0; idxB = '0; cntB = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entValid[i] && entWin[i] == qryA) begin
        hitA = 1'b1; idxA = IDX_W'(i); cntA = entCnt[i];
      end
      if (entValid[i] && entWin[i] == qryB) begin
        hitB = 1'b1; idxB = IDX_W'(i); cntB = entCnt[i];
      end
    end
  end

  // First two free entries
  always_comb begin
    freeIdx0 = '0;
    freeIdx1 = '0;
    nFree    = 2'd0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!entValid[i]) begin
        if (nFree == 2'd0)      freeIdx0 = IDX_W'(i);
        else if (nFree == 2'd1) freeIdx1 = IDX_W'(i);
        if (nFree != 2'd2) nFree = nFree + 2'd1;
      end
    end
  end

  assign freeAny = (nFree != 2'd0);
  assign freeTwo = (nFree == 2'd2);

  assign incA  = strobe.sameWin ? CNT_W'(2) : CNT_W'(1);
  assign slotB = hitB ? idxB : ((strobe.bookA && !hitA) ? freeIdx1 : freeIdx0);

  // Next table state: prune expired windows, then book the grant
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nxtValid[i] = entValid[i] && !(entWin[i] < nowWin);
      nxtWin[i]   = entWin[i];
      nxtCnt[i]   = entCnt[i];
    end
    if (strobe.bookA) begin
      if (hitA) begin
        nxtCnt[idxA] = entCnt[idxA] + incA;
      end else begin
        nxtValid[freeIdx0] = 1'b1;
        nxtWin[freeIdx0]   = qryA;
        nxtCnt[freeIdx0]   = incA;
      end
    end
    if (strobe.bookB && !(strobe.bookA && strobe.sameWin)) begin
      if (hitB) begin
        nxtCnt[slotB] = entCnt[slotB] + CNT_W'(1);
      end else begin
        nxtValid[slotB] = 1'b1;
        nxtWin[slotB]   = qryB;
        nxtCnt[slotB]   = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        entValid[i] <= 1'b0;
        entWin[i]   <= '0;
        entCnt[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        entValid[i] <= nxtValid[i];
        entWin[i]   <= nxtWin[i];
        entCnt[i]   <= nxtCnt[i];
      end
    end
  end

  // ---------------- assertions ----------------
  logic dupKey;
  always_comb begin
    dupKey = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = i + 1; j < DEPTH; j++) begin
        if (entValid[i] && entValid[j] && entWin[i] == entWin[j]) dupKey = 1'b1;
      end
    end
  end

  // R7: one entry per window, so bookings of a window never split
  p_unique_window_r7: assert property (@(posedge clk) disable iff (!rstN) !dupKey);

  // R8: nothing is booked into a window that has already ended
  p_book_not_past_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bookB |-> (qryB >= nowWin));

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entChk
      // R7: a live booking count never drops while its window is kept
      p_count_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
        (entValid[g] && $past(entValid[g]) && entWin[g] == $past(entWin[g]))
          |-> (entCnt[g] >= $past(entCnt[g])));
    end
  endgenerate

endmodule

// File: rtl/cmdbw_ctrl.sv
module cmdbw_ctrl
  import cmdbw_pkg::*;
#(
  parameter int TIME_W   = 32,
  parameter int WIN_LOG2 = 2,
  parameter int CNT_W    = 4,
  parameter int GAP_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] nowCycle,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [TIME_W-1:0] reqCycle,
  input  logic              reqTwoPart,
  input  logic [CNT_W-1:0]  reqMaxCmds,
  input  logic [GAP_W-1:0]  reqMaxGapWin,
  output logic [TIME_W-1:0] qryA,
  output logic [TIME_W-1:0] qryB,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  input  logic              hitA,
  input  logic              hitB,
  input  logic              freeAny,
  input  logic              freeTwo,
  output book_strobe_t      strobe,
  output logic              grantValid,
  output logic [TIME_W-1:0] grantFirst,
  output logic [TIME_W-1:0] grantSecond
);

  localparam int CW1 = CNT_W + 1;
  localparam logic [TIME_W-1:0] WIN_LEN    = TIME_W'(1) << WIN_LOG2;
  localparam logic [TIME_W-1:0] ALIGN_MASK = ~(WIN_LEN - TIME_W'(1));

  function automatic logic [TIME_W-1:0] laterOf(input logic [TIME_W-1:0] a,
                                                 input logic [TIME_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  bw_state_e         state;
  logic [TIME_W-1:0] rCycle, rSpan, winA, winB;
  logic              rTwo;
  logic [CNT_W-1:0]  rMax;

  logic [TIME_W-1:0] nowWin, effA, effB, nextA, nextB, firstAt, secondAt;
  logic [TIME_W-1:0] reqWin, reqSpan;
  logic [CW1-1:0]    cA, cB, mx;
  logic              sameWin, okA, okB, fit, room, needOne, needTwo, grantNow;

  assign reqReady = (state == ST_IDLE);
  assign nowWin   = nowCycle & ALIGN_MASK;
  assign reqWin   = reqCycle & ALIGN_MASK;
  assign reqSpan  = TIME_W'(reqMaxGapWin) << WIN_LOG2;

  always_comb begin
    effA    = (winA < nowWin) ? nowWin : winA;
    effB    = (winB < nowWin) ? nowWin : winB;
    sameWin = rTwo && (effA == effB);
    cA      = {1'b0, cntA};
    cB      = sameWin ? (cA + CW1'(1)) : {1'b0, cntB};
    mx      = {1'b0, rMax};
    okA     = !rTwo || (cA < mx);
    okB     = (cB < mx);
    fit     = okA && okB;
    needTwo = rTwo && !sameWin && !hitA && !hitB;
    needOne = !hitB || (rTwo && !sameWin && !hitA);
    room    = needTwo ? freeTwo : (needOne ? freeAny : 1'b1);
    grantNow = (state == ST_SEARCH) && fit && room;

    nextB = okB ? effB : (effB + WIN_LEN);
    nextA = (rTwo && (!okA || (!okB && ((nextB - effA) > rSpan))))
            ? (effA + WIN_LEN) : effA;

    secondAt = laterOf(laterOf(effB, rCycle), nowCycle);
    firstAt  = rTwo ? laterOf(effA, nowCycle) : secondAt;

    qryA           = effA;
    qryB           = effB;
    strobe.bookA   = grantNow && rTwo;
    strobe.bookB   = grantNow;
    strobe.sameWin = sameWin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      rCycle      <= '0;
      rSpan       <= '0;
      winA        <= '0;
      winB        <= '0;
      rTwo        <= 1'b0;
      rMax        <= '0;
      grantValid  <= 1'b0;
      grantFirst  <= '0;
      grantSecond <= '0;
    end else begin
      grantValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            rCycle <= reqCycle;
            rTwo   <= reqTwoPart;
            rMax   <= reqMaxCmds;
            rSpan  <= reqSpan;
            winB   <= reqWin;
            winA   <= (reqWin >= reqSpan) ? (reqWin - reqSpan) : '0;
            state  <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (grantNow) begin
            grantValid  <= 1'b1;
            grantFirst  <= firstAt;
            grantSecond <= secondAt;
            state       <= ST_IDLE;
          end else if (!fit) begin
            winA <= nextA;
            winB <= nextB;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // R1: a grant is never earlier than the requested cycle
  p_not_early_r1: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantSecond >= rCycle));

  // R4: the first part never follows the second
  p_part_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantFirst <= grantSecond));

  // R6: the two parts stay within the allowed separation
  p_split_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && rTwo) |->
      (((grantSecond & ALIGN_MASK) - (grantFirst & ALIGN_MASK)) <= rSpan));

  // R10: one grant pulse per accepted request
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !grantValid);

endmodule

// File: rtl/cmd_bus_budget.sv
module cmd_bus_budget
  import cmdbw_pkg::*;
#(
  parameter int TIME_W   = 32,
  parameter int WIN_LOG2 = 2,
  parameter int DEPTH    = 8,
  parameter int CNT_W    = 4,
  parameter int GAP_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] nowCycle,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [TIME_W-1:0] reqCycle,
  input  logic              reqTwoPart,
  input  logic [CNT_W-1:0]  reqMaxCmds,
  input  logic [GAP_W-1:0]  reqMaxGapWin,
  output logic              grantValid,
  output logic [TIME_W-1:0] grantFirst,
  output logic [TIME_W-1:0] grantSecond
);

  logic [TIME_W-1:0] qryA, qryB;
  logic [CNT_W-1:0]  cntA, cntB;
  logic              hitA, hitB, freeAny, freeTwo;
  book_strobe_t      strobe;

  cmdbw_ctrl #(
    .TIME_W(TIME_W), .WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W), .GAP_W(GAP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .nowCycle(nowCycle),
    .reqValid(reqValid), .reqReady(reqReady), .reqCycle(reqCycle),
    .reqTwoPart(reqTwoPart), .reqMaxCmds(reqMaxCmds), .reqMaxGapWin(reqMaxGapWin),
    .qryA(qryA), .qryB(qryB), .cntA(cntA), .cntB(cntB),
    .hitA(hitA), .hitB(hitB), .freeAny(freeAny), .freeTwo(freeTwo),
    .strobe(strobe),
    .grantValid(grantValid), .grantFirst(grantFirst), .grantSecond(grantSecond)
  );

  cmdbw_table #(
    .TIME_W(TIME_W), .WIN_LOG2(WIN_LOG2), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_table (
    .clk(clk), .rstN(rstN), .nowCycle(nowCycle),
    .qryA(qryA), .qryB(qryB), .strobe(strobe),
    .cntA(cntA), .cntB(cntB), .hitA(hitA), .hitB(hitB),
    .freeAny(freeAny), .freeTwo(freeTwo)
  );

endmodule

// File: tb/sim_cmd_bus_budget.sv
module sim_cmd_bus_budget;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] nowCycle;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqCycle = '0;
  logic        reqTwoPart = 1'b0;
  logic [3:0]  reqMaxCmds = 4'd1;
  logic [3:0]  reqMaxGapWin = 4'd0;
  logic        grantValid;
  logic [31:0] grantFirst, grantSecond;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [31:0] gFirst, gSecond, gNow;

  always #2 clk = ~clk;  // 250 MHz

  always_ff @(posedge clk) begin
    if (!rstN) nowCycle <= '0;
    else       nowCycle <= nowCycle + 32'd1;
  end

  cmd_bus_budget u0 (
    .clk(clk), .rstN(rstN), .nowCycle(nowCycle),
    .reqValid(reqValid), .reqReady(reqReady), .reqCycle(reqCycle),
    .reqTwoPart(reqTwoPart), .reqMaxCmds(reqMaxCmds), .reqMaxGapWin(reqMaxGapWin),
    .grantValid(grantValid), .grantFirst(grantFirst), .grantSecond(grantSecond)
  );

  function automatic logic [31:0] alignW(input logic [31:0] x);
    return x & ~32'd3;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sendReq(input logic [31:0] cyc, input bit two, input int mx,
                         input int gap);
    @(negedge clk);
    for (int w = 0; w < 1000 && !reqReady; w++) @(negedge clk);
    reqCycle     = cyc;
    reqTwoPart   = two;
    reqMaxCmds   = 4'(mx);
    reqMaxGapWin = 4'(gap);
    reqValid     = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic waitGrant();
    bit got = 1'b0;
    for (int w = 0; w < 2000 && !got; w++) begin
      @(negedge clk);
      if (grantValid) begin
        got     = 1'b1;
        gFirst  = grantFirst;
        gSecond = grantSecond;
        gNow    = nowCycle - 32'd1;
      end
    end
    if (!got) check(1'b0, "grant timeout", 0, 1);
  endtask

  task automatic issue(input logic [31:0] cyc, input bit two, input int mx,
                       input int gap);
    sendReq(cyc, two, mx, gap);
    waitGrant();
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(reqReady == 1'b1, "R10 ready after reset", 32'(reqReady), 1);
    check(grantValid == 1'b0, "R10 no grant after reset", 32'(grantValid), 0);
  endtask

  task automatic t_single();
    logic [31:0] b;
    b = alignW(nowCycle) + 32'd32;
    issue(b + 1, 1'b0, 2, 0);
    check(gSecond == b + 1, "R1 grant at requested cycle", gSecond, b + 1);
    check(gFirst == gSecond, "R1 single parts equal", gFirst, gSecond);
    issue(b + 2, 1'b0, 2, 0);
    check(gSecond == b + 2, "R7 second booking seen, room left", gSecond, b + 2);
    issue(b + 3, 1'b0, 2, 0);
    check(gSecond == b + 4, "R2 moved grant at window start", gSecond, b + 4);
    issue(b + 1, 1'b0, 2, 0);
    check(gSecond == b + 4, "R3 full window skipped", gSecond, b + 4);
    issue(b + 0, 1'b0, 2, 0);
    check(gSecond == b + 8, "R3 repeated window skip", gSecond, b + 8);
  endtask

  task automatic t_twoPart();
    logic [31:0] c;
    c = alignW(nowCycle) + 32'd32;
    issue(c + 2, 1'b1, 2, 1);
    check(gFirst == c - 4, "R4 first part one window back", gFirst, c - 4);
    check(gSecond == c + 2, "R4 second part at request", gSecond, c + 2);
    issue(c + 1, 1'b1, 2, 0);
    check(gSecond == c + 4, "R5 same window needs two slots", gSecond, c + 4);
    check(gFirst == c + 4, "R6 first advanced with second", gFirst, c + 4);
  endtask

  task automatic t_gap();
    logic [31:0] d;
    d = alignW(nowCycle) + 32'd32;
    issue(d, 1'b0, 1, 0);
    check(gSecond == d, "R1 fill window", gSecond, d);
    issue(d + 1, 1'b1, 1, 1);
    check(gFirst == d + 4, "R6 first part after gap retries", gFirst, d + 4);
    check(gSecond == d + 8, "R6 second part after gap retries", gSecond, d + 8);
  endtask

  task automatic t_clamp();
    logic [31:0] p;
    p = alignW(nowCycle) + 32'd8;
    issue(p + 1, 1'b1, 4, 8);
    check(gFirst == gNow, "R4 first part clamped to current cycle", gFirst, gNow);
    check(gSecond == p + 1, "R4 second part at request", gSecond, p + 1);
  endtask

  task automatic t_full();
    logic [31:0] e;
    e = alignW(nowCycle) + 32'd64;
    for (int k = 0; k < 8; k++) begin
      issue(e + 32'(4 * k), 1'b0, 1, 0);
      check(gSecond == e + 32'(4 * k), "R9 table fill grant", gSecond, e + 32'(4 * k));
    end
    sendReq(e + 32, 1'b0, 1, 0);
    @(negedge clk);
    check(reqReady == 1'b0, "R10 ready low while searching", 32'(reqReady), 0);
    check(grantValid == 1'b0, "R9 no grant while table full", 32'(grantValid), 0);
    waitGrant();
    check(gSecond == e + 32, "R9 grant after entry freed", gSecond, e + 32);
    check(gNow >= e + 4, "R8 grant only after oldest window expired", gNow, e + 4);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_single();
    drain();
    t_twoPart();
    drain();
    t_gap();
    drain();
    t_clamp();
    drain();
    t_full();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule